// File: doc/BRIEF.md
# Character Display Bus Transaction Engine

This block turns single requests from a host into timed transfers on an asynchronous parallel character-display bus. The bus has a register-select line, a read/write line, an enable strobe and eight data lines (separate output, output-enable and input so the tristate sits outside the block). The host presents one of four operations as a two-bit code: instruction write, status read, RAM data write or RAM data read. It gets back an acknowledge pulse when the request is taken and a completion pulse when the transfer has finished, together with any byte read from the display.

Every bus time is counted in system clocks. Address setup, strobe width, data setup and hold, read access time and the minimum strobe period are given in nanoseconds as parameters, and the clock period is a parameter too. Each time becomes a whole number of clocks, rounded up, with a minimum of one. A mode input chooses between whole-byte transfers and narrow transfers. In narrow mode each byte moves as two strobes on the upper four data lines. A busy-poll request repeats status reads until the busy bit is clear, and only then reports completion.

Top module: `chardisp_bus_engine`

## Requirements
- R1: The bus select and direction lines carry the request code, op = {select, direction}: 00 instruction write, 01 status read, 10 data write, 11 data read. `bus_oe` is 1 for the whole strobe of a write and 0 for the whole strobe of a read, and it is never 1 while `bus_rw` is 1.
- R2: Select and direction settle at least ceil(30 ns / clock) clocks before the strobe rises. Select, direction and write data do not change while the strobe is high, and they do not change in the clock after it falls.
- R3: The strobe stays high at least ceil(150 ns / clock) clocks, and successive rising edges of the strobe are at least ceil(400 ns / clock) clocks apart.
- R4: A read samples `bus_din` in the last clock of the high strobe. The byte read appears on `rdata` in the cycle where `done` is 1.
- R5: With `nib_mode` = 1, each byte uses exactly two strobes with the high nibble first. The nibble is on bus bits 7..4 and bus bits 3..0 are 0. A read puts the first nibble sampled on bits 7..4 and the second on bits 3..0. With `nib_mode` = 0, each byte uses one strobe with all eight bits.
- R6: With `poll` = 1, the request code is ignored and status reads are repeated. Bit 7 of the assembled status byte is the busy bit, so in narrow mode it comes from the first nibble. `done` comes only after a status byte whose bit 7 is 0, and `rdata` then holds that byte.
- R7: `ack` pulses for exactly one clock per accepted request. `done` pulses for exactly one clock per finished request. A request held high during a transfer is not taken again.
- R8: `bus_oe` is 0 in the sample before any rise of `bus_rw`.
- R9: During and right after reset the strobe, `bus_oe`, `ack` and `done` are all 0.
- R10: `nib_mode`, `op`, `poll` and `wdata` are captured when the request is acknowledged. Changing them during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| op | input | 2 | Request code {select, direction} |
| poll | input | 1 | Repeat status reads until not busy |
| nib_mode | input | 1 | 1: two 4-bit strobes per byte on bits 7..4 |
| wdata | input | 8 | Byte to write |
| ack | output | 1 | Request taken (one clock) |
| done | output | 1 | Request finished (one clock) |
| rdata | output | 8 | Last byte read |
| bus_rs | output | 1 | Register select to display |
| bus_rw | output | 1 | Direction to display, 1 = read |
| bus_en | output | 1 | Enable strobe |
| bus_dout | output | 8 | Data driven to display |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 8 | Data returned by display |

## Verification
In the busy-poll path, the decision to start another status read happens in the same cycle that the last nibble of the previous read is assembled. The bench provokes this with a display model that reports busy for a chosen number of full status bytes, in both bus widths. It counts the strobes the scoreboard expects, and it compares the final status byte carried with `done`. The same scoreboard also covers a second case: a request held high, and a mode input flipped, while a transfer is in progress. These are judged by the number of `ack` pulses and by the strobe pattern, which must follow the mode captured at acceptance.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  localparam int BUS_W = 8;
  localparam int NIB_W = 4;

  // clocks needed to cover a time in ns, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD, PH_PAD} phase_t;
endpackage

// File: rtl/chardisp_beat.sv
// One enable cycle on the display bus: setup, high, hold, pad to period.
module chardisp_beat
  import chardisp_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int T_AS_NS  = 30,
  parameter int T_AH_NS  = 10,
  parameter int T_PW_NS  = 150,
  parameter int T_CYC_NS = 400,
  parameter int T_DSW_NS = 40,
  parameter int T_DH_NS  = 10,
  parameter int T_DDR_NS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             rs_i,
  input  logic             rw_i,
  input  logic [BUS_W-1:0] byte_i,
  input  logic [BUS_W-1:0] din,
  output logic             fin,
  output logic [BUS_W-1:0] cap,
  output logic             bus_rs,
  output logic             bus_rw,
  output logic             bus_en,
  output logic             bus_oe,
  output logic [BUS_W-1:0] bus_dout
);
  localparam int N_AS   = ns2cyc(T_AS_NS, CLK_NS);
  localparam int N_HI   = imax(imax(ns2cyc(T_PW_NS, CLK_NS), ns2cyc(T_DSW_NS, CLK_NS)),
                               ns2cyc(T_DDR_NS, CLK_NS));
  localparam int N_HOLD = imax(ns2cyc(T_AH_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS));
  localparam int N_USED = N_AS + N_HI + N_HOLD;
  localparam int N_PAD  = imax(1, ns2cyc(T_CYC_NS, CLK_NS) - N_USED);
  localparam int N_MAX  = imax(imax(N_AS, N_HI), imax(N_HOLD, N_PAD));
  localparam int CW     = $clog2(N_MAX + 1);

  phase_t        ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      fin      <= 1'b0;
      cap      <= '0;
      bus_rs   <= 1'b0;
      bus_rw   <= 1'b0;
      bus_en   <= 1'b0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          bus_rs   <= rs_i;
          bus_rw   <= rw_i;
          bus_oe   <= ~rw_i;
          bus_dout <= byte_i;
          cnt      <= CW'(N_AS - 1);
          ph       <= PH_SETUP;
        end
        PH_SETUP: if (cnt == '0) begin
          bus_en <= 1'b1;
          cnt    <= CW'(N_HI - 1);
          ph     <= PH_HIGH;
        end else cnt <= cnt - 1'b1;
        PH_HIGH: if (cnt == '0) begin
          bus_en <= 1'b0;
          cap    <= din;            // last clock of the high phase
          cnt    <= CW'(N_HOLD - 1);
          ph     <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          bus_oe <= 1'b0;           // released ahead of any direction change
          cnt    <= CW'(N_PAD - 1);
          ph     <= PH_PAD;
        end else cnt <= cnt - 1'b1;
        PH_PAD: if (cnt == '0) begin
          fin <= 1'b1;
          ph  <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chardisp_xfer.sv
// Splits a byte into one or two enable cycles and gathers read nibbles.
module chardisp_xfer
  import chardisp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rs_i,
  input  logic             rw_i,
  input  logic             nib_i,
  input  logic [BUS_W-1:0] byte_i,
  output logic             fin,
  output logic [BUS_W-1:0] rbyte,
  output logic             beat_go,
  output logic             beat_rs,
  output logic             beat_rw,
  output logic [BUS_W-1:0] beat_byte,
  input  logic             beat_fin,
  input  logic [BUS_W-1:0] beat_cap
);
  typedef enum logic [1:0] {XS_IDLE, XS_FIRST, XS_SECOND} xs_t;

  xs_t              xs;
  logic             nib_q;
  logic [NIB_W-1:0] lo_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xs        <= XS_IDLE;
      nib_q     <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      fin       <= 1'b0;
      rbyte     <= '0;
      beat_go   <= 1'b0;
      beat_rs   <= 1'b0;
      beat_rw   <= 1'b0;
      beat_byte <= '0;
    end else begin
      fin     <= 1'b0;
      beat_go <= 1'b0;
      case (xs)
        XS_IDLE: if (start) begin
          beat_rs   <= rs_i;
          beat_rw   <= rw_i;
          nib_q     <= nib_i;
          lo_q      <= byte_i[NIB_W-1:0];
          beat_byte <= nib_i ? {byte_i[BUS_W-1:NIB_W], {NIB_W{1'b0}}} : byte_i;
          beat_go   <= 1'b1;
          xs        <= XS_FIRST;
        end
        XS_FIRST: if (beat_fin) begin
          if (nib_q) begin
            hi_q      <= beat_cap[BUS_W-1:NIB_W];
            beat_byte <= {lo_q, {NIB_W{1'b0}}};
            beat_go   <= 1'b1;
            xs        <= XS_SECOND;
          end else begin
            rbyte <= beat_cap;
            fin   <= 1'b1;
            xs    <= XS_IDLE;
          end
        end
        XS_SECOND: if (beat_fin) begin
          rbyte <= {hi_q, beat_cap[BUS_W-1:NIB_W]};
          fin   <= 1'b1;
          xs    <= XS_IDLE;
        end
        default: xs <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chardisp_bus_engine.sv
// Host request/acknowledge front end with busy polling.
module chardisp_bus_engine
  import chardisp_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int T_AS_NS  = 30,
  parameter int T_AH_NS  = 10,
  parameter int T_PW_NS  = 150,
  parameter int T_CYC_NS = 400,
  parameter int T_DSW_NS = 40,
  parameter int T_DH_NS  = 10,
  parameter int T_DDR_NS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [1:0]       op,
  input  logic             poll,
  input  logic             nib_mode,
  input  logic [BUS_W-1:0] wdata,
  output logic             ack,
  output logic             done,
  output logic [BUS_W-1:0] rdata,
  output logic             bus_rs,
  output logic             bus_rw,
  output logic             bus_en,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_din
);
  typedef enum logic {TS_IDLE, TS_RUN} ts_t;

  ts_t              ts;
  logic [1:0]       op_q;
  logic             poll_q;
  logic             nib_q;
  logic [BUS_W-1:0] wd_q;
  logic             x_start;
  logic             x_fin;
  logic [BUS_W-1:0] x_rbyte;
  logic             b_go, b_rs, b_rw, b_fin;
  logic [BUS_W-1:0] b_byte, b_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts      <= TS_IDLE;
      op_q    <= '0;
      poll_q  <= 1'b0;
      nib_q   <= 1'b0;
      wd_q    <= '0;
      x_start <= 1'b0;
      ack     <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      ack     <= 1'b0;
      done    <= 1'b0;
      x_start <= 1'b0;
      case (ts)
        TS_IDLE: if (req) begin
          ack     <= 1'b1;
          op_q    <= poll ? 2'b01 : op;
          poll_q  <= poll;
          nib_q   <= nib_mode;
          wd_q    <= wdata;
          x_start <= 1'b1;
          ts      <= TS_RUN;
        end
        TS_RUN: if (x_fin) begin
          if (poll_q && x_rbyte[BUS_W-1]) begin
            x_start <= 1'b1;          // still busy: read status again
          end else begin
            done <= 1'b1;
            if (op_q[0]) rdata <= x_rbyte;
            ts <= TS_IDLE;
          end
        end
        default: ts <= TS_IDLE;
      endcase
    end
  end

  chardisp_xfer u_xfer (
    .clk(clk), .rst(rst), .start(x_start),
    .rs_i(op_q[1]), .rw_i(op_q[0]), .nib_i(nib_q), .byte_i(wd_q),
    .fin(x_fin), .rbyte(x_rbyte),
    .beat_go(b_go), .beat_rs(b_rs), .beat_rw(b_rw), .beat_byte(b_byte),
    .beat_fin(b_fin), .beat_cap(b_cap)
  );

  chardisp_beat #(
    .CLK_NS(CLK_NS), .T_AS_NS(T_AS_NS), .T_AH_NS(T_AH_NS), .T_PW_NS(T_PW_NS),
    .T_CYC_NS(T_CYC_NS), .T_DSW_NS(T_DSW_NS), .T_DH_NS(T_DH_NS), .T_DDR_NS(T_DDR_NS)
  ) u_beat (
    .clk(clk), .rst(rst), .go(b_go), .rs_i(b_rs), .rw_i(b_rw), .byte_i(b_byte),
    .din(bus_din), .fin(b_fin), .cap(b_cap),
    .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en), .bus_oe(bus_oe),
    .bus_dout(bus_dout)
  );
endmodule

// File: rtl/chardisp_checker.sv
module chardisp_checker
  import chardisp_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int T_AS_NS  = 30,
  parameter int T_PW_NS  = 150,
  parameter int T_CYC_NS = 400
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rs,
  input logic             bus_rw,
  input logic             bus_en,
  input logic             bus_oe,
  input logic [BUS_W-1:0] bus_dout,
  input logic             ack,
  input logic             done
);
  localparam logic [15:0] C_AS  = 16'(ns2cyc(T_AS_NS, CLK_NS));
  localparam logic [15:0] C_PW  = 16'(ns2cyc(T_PW_NS, CLK_NS));
  localparam logic [15:0] C_CYC = 16'(ns2cyc(T_CYC_NS, CLK_NS));

  logic [15:0] since_chg, hi_cnt, rr_cnt;
  logic        rs_d, rw_d, en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_chg <= '0;
      hi_cnt    <= '0;
      rr_cnt    <= 16'hFFFF;
      rs_d      <= 1'b0;
      rw_d      <= 1'b0;
      en_d      <= 1'b0;
    end else begin
      rs_d <= bus_rs;
      rw_d <= bus_rw;
      en_d <= bus_en;
      if (bus_rs != rs_d || bus_rw != rw_d) since_chg <= 16'd1;
      else if (since_chg != 16'hFFFF)       since_chg <= since_chg + 16'd1;
      hi_cnt <= bus_en ? hi_cnt + 16'd1 : 16'd0;
      if (bus_en && !en_d)         rr_cnt <= 16'd1;
      else if (rr_cnt != 16'hFFFF) rr_cnt <= rr_cnt + 16'd1;
    end
  end

  assert_oe_dir_R1: assert property (@(posedge clk) disable iff (rst) bus_oe |-> !bus_rw);
  assert_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en) |-> since_chg >= C_AS);
  assert_steady_high_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && $past(bus_en)) |-> ($stable(bus_rs) && $stable(bus_rw) && $stable(bus_dout)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_en) |=> ($stable(bus_rs) && $stable(bus_rw) && $stable(bus_dout)));
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_en) |-> hi_cnt >= C_PW);
  assert_period_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en) |-> rr_cnt >= C_CYC);
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rw) |-> $past(!bus_oe));
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!bus_en && !bus_oe && !ack && !done));
endmodule

bind chardisp_bus_engine chardisp_checker #(
  .CLK_NS(CLK_NS), .T_AS_NS(T_AS_NS), .T_PW_NS(T_PW_NS), .T_CYC_NS(T_CYC_NS)
) u_chk (
  .clk(clk), .rst(rst), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en),
  .bus_oe(bus_oe), .bus_dout(bus_dout), .ack(ack), .done(done)
);

// File: tb/chardisp_bus_engine_test.sv
module chardisp_bus_engine_test;
  // expected clock counts at a 20 ns clock: 30 ns -> 2, 150 ns -> 8, 400 ns -> 20
  localparam int E_AS  = 2;
  localparam int E_PW  = 8;
  localparam int E_CYC = 20;

  typedef struct packed {logic rs; logic rw; logic [7:0] d;} beat_t;
  typedef struct packed {logic chk; logic [7:0] v;} res_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, poll = 1'b0, nib_mode = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic ack, done, bus_rs, bus_rw, bus_en, bus_oe;
  logic [7:0] rdata, bus_dout, bus_din;

  chardisp_bus_engine uut (
    .clk(clk), .rst(rst), .req(req), .op(op), .poll(poll), .nib_mode(nib_mode),
    .wdata(wdata), .ack(ack), .done(done), .rdata(rdata), .bus_rs(bus_rs),
    .bus_rw(bus_rw), .bus_en(bus_en), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, ack_cnt = 0;
  bit finished = 0;
  beat_t beat_q[$];
  res_t  res_q[$];

  // display model
  int busy_left = 0;
  logic [6:0] dev_ac = '0;
  logic [7:0] dev_rd = '0;
  bit dev_nib = 0, phase = 0;
  logic [7:0] sel;
  always_comb begin
    sel = bus_rs ? dev_rd : {busy_left != 0, dev_ac};
    bus_din = dev_nib ? (phase ? {sel[3:0], 4'h0} : {sel[7:4], 4'h0}) : sel;
  end

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor
  int last_chg = 0, last_rise = 0;
  bit seen_rise = 0, en_p = 0, oe_p = 0;
  logic [1:0] rsrw_p = 2'b00;
  always @(negedge clk) begin
    if (!rst) begin
      if ({bus_rs, bus_rw} != rsrw_p) last_chg = cyc;
      if (bus_rw && !rsrw_p[0]) chk(!oe_p && !bus_oe, "R8 oe before rw rise", oe_p, 0);
      if (bus_en && !en_p) begin
        chk(cyc - last_chg >= E_AS, "R2 setup clocks", cyc - last_chg, E_AS);
        if (seen_rise) chk(cyc - last_rise >= E_CYC, "R3 period", cyc - last_rise, E_CYC);
        seen_rise = 1;
        last_rise = cyc;
      end
      if (!bus_en && en_p) begin
        beat_t b;
        chk(cyc - last_rise >= E_PW, "R3 high width", cyc - last_rise, E_PW);
        if (beat_q.size() == 0) chk(0, "R5 extra strobe", 1, 0);
        else begin
          b = beat_q.pop_front();
          chk({bus_rs, bus_rw} == {b.rs, b.rw}, "R1 op code", {bus_rs, bus_rw}, {b.rs, b.rw});
          if (!b.rw) begin
            chk(bus_oe, "R1 oe on write", bus_oe, 1);
            chk(bus_dout == b.d, "R1/R5 write data", bus_dout, b.d);
          end else chk(!bus_oe, "R1 oe off on read", bus_oe, 0);
        end
        if (dev_nib) begin
          if (phase && !bus_rs && bus_rw && busy_left > 0) busy_left--;
          phase = !phase;
        end else if (!bus_rs && bus_rw && busy_left > 0) busy_left--;
      end
      if (done) begin
        res_t r;
        chk(beat_q.size() == 0, "R5 strobe count", beat_q.size(), 0);
        if (res_q.size() == 0) chk(0, "R7 extra done", 1, 0);
        else begin
          r = res_q.pop_front();
          if (r.chk) chk(rdata == r.v, "R4/R6 read byte", rdata, r.v);
        end
      end
      if (ack) ack_cnt++;
      en_p = bus_en; oe_p = bus_oe; rsrw_p = {bus_rs, bus_rw};
    end
  end

  task automatic push_byte(input logic rs, input logic rw, input logic [7:0] d, input bit nb);
    if (nb) begin
      beat_q.push_back('{rs, rw, {d[7:4], 4'h0}});
      beat_q.push_back('{rs, rw, {d[3:0], 4'h0}});
    end else beat_q.push_back('{rs, rw, d});
  endtask

  // driver
  task automatic txn(input logic [1:0] opv, input logic [7:0] wd, input bit pl, input bit nb,
                     input int busy, input logic [7:0] rd, input logic [6:0] acv,
                     input int hold, input bit flip);
    int a0;
    busy_left = busy; dev_rd = rd; dev_ac = acv; dev_nib = nb; phase = 0;
    if (pl) begin
      for (int i = 0; i <= busy; i++) push_byte(1'b0, 1'b1, 8'h00, nb);
      res_q.push_back('{1'b1, {1'b0, acv}});
    end else begin
      push_byte(opv[1], opv[0], wd, nb);
      if (opv == 2'b11)      res_q.push_back('{1'b1, rd});
      else if (opv == 2'b01) res_q.push_back('{1'b1, {busy != 0, acv}});
      else                   res_q.push_back('{1'b0, 8'h00});
    end
    @(negedge clk);
    a0 = ack_cnt;
    op = opv; wdata = wd; poll = pl; nib_mode = nb; req = 1'b1;
    do @(negedge clk); while (!ack);
    if (flip) begin nib_mode = !nb; op = ~opv; wdata = ~wd; end
    repeat (hold) @(negedge clk);
    req = 1'b0;
    do @(negedge clk); while (!done);
    @(negedge clk);
    chk(ack_cnt == a0 + 1, "R7 one ack per request", ack_cnt - a0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!bus_en && !bus_oe && !ack && !done, "R9 reset outputs",
        {bus_en, bus_oe, ack, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_en && !bus_oe && !ack && !done, "R9 after reset",
        {bus_en, bus_oe, ack, done}, 0);
    // R1 R2 R3: byte writes and reads
    txn(2'b00, 8'h38, 0, 0, 0, 8'h00, 7'h00, 0, 0);
    txn(2'b10, 8'hA5, 0, 0, 0, 8'h00, 7'h00, 0, 0);
    // R4: data read then status reads
    txn(2'b11, 8'h00, 0, 0, 0, 8'h5C, 7'h00, 0, 0);
    txn(2'b01, 8'h00, 0, 0, 0, 8'h00, 7'h15, 0, 0);
    txn(2'b01, 8'h00, 0, 0, 1, 8'h00, 7'h2A, 0, 0);
    // R5: narrow mode write, read, status
    txn(2'b00, 8'hC3, 0, 1, 0, 8'h00, 7'h00, 0, 0);
    txn(2'b11, 8'h00, 0, 1, 0, 8'h9E, 7'h00, 0, 0);
    txn(2'b10, 8'h7B, 0, 1, 0, 8'h00, 7'h00, 0, 0);
    txn(2'b01, 8'h00, 0, 1, 1, 8'h00, 7'h63, 0, 0);
    // R6: busy polling in both widths, op code ignored
    txn(2'b10, 8'hFF, 1, 0, 3, 8'h00, 7'h22, 0, 0);
    txn(2'b00, 8'h00, 1, 1, 2, 8'h00, 7'h41, 0, 0);
    txn(2'b01, 8'h00, 1, 0, 0, 8'h00, 7'h7F, 0, 0);
    // R7: request held during transfer; R10: inputs changed after ack
    txn(2'b10, 8'h3C, 0, 0, 0, 8'h00, 7'h00, 10, 0);
    txn(2'b00, 8'h96, 0, 1, 0, 8'h00, 7'h00, 3, 1);
    txn(2'b11, 8'h00, 0, 0, 0, 8'hE1, 7'h00, 0, 1);
    chk(beat_q.size() == 0 && res_q.size() == 0, "R5/R7 scoreboard drained",
        beat_q.size() + res_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule